// File: doc/BRIEF.md
# Dual-Address DMA Channel Sequencer

This block is the transfer engine of a single DMA channel. Software loads a requester start address, a target start address, a byte count and a set of mode bits in one load cycle. An external arbiter then pulses `xfer_go` once for each bus transfer it grants. On every transfer the block moves its two address pointers and reduces the remaining count. It presents the current source and destination addresses and their memory/I/O spaces to the bus engine.

The two address streams are independent. Each stream has its own modify enable, its own count direction, its own memory/I/O space and its own 8-bit or 16-bit width. A mode bit places the target on the destination side or on the source side. The channel finishes when the count runs out or when an end-of-process input arrives with a transfer. At that point a sticky terminal flag is set. If auto-reload is enabled, the pointers and the count return to their loaded start values and the channel stays armed. Otherwise the channel stops until it is loaded again. A status-read strobe clears the terminal flag.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, `chan_active` and `tc_flag` are 0, and both addresses and `cur_count` are 0.
- R2: A `cfg_load` cycle sets the requester and target pointers to their base inputs and `cur_count` to `cfg_count`, and sets `chan_active` to 1. A `xfer_go` in the same cycle is ignored.
- R3: With `cfg_tgt_is_dst`=1, `dst_addr`/`dst_is_io` show the target stream and `src_addr`/`src_is_io` show the requester stream. With `cfg_tgt_is_dst`=0 the two sides are swapped.
- R4: On a transfer, the requester pointer changes only when `cfg_req_mod`=1. It then moves by 2 when `cfg_req_16`=1 and by 1 otherwise. It moves down when `cfg_req_down`=1 and up otherwise, modulo 2^AW.
- R5: The target pointer follows the same rule, using `cfg_tgt_mod`, `cfg_tgt_16` and `cfg_tgt_down`.
- R6: `xfer_bytes` is 2 when both sides are 16-bit and 1 otherwise. A non-terminal transfer lowers `cur_count` by `xfer_bytes`.
- R7: A transfer is terminal when `cur_count` < `xfer_bytes`. Without auto-reload, a terminal transfer still steps the pointers, sets `cur_count` to `cur_count - xfer_bytes` modulo 2^CW, sets `tc_flag` and clears `chan_active`. While `chan_active`=0, `xfer_go` changes no output.
- R8: With `cfg_autoinit`=1, a terminal transfer restores both pointers and `cur_count` to their loaded start values, sets `tc_flag`, and keeps `chan_active` at 1.
- R9: An `eop` that is high together with an accepted transfer makes that transfer terminal, with the same effects as in R7 and R8.
- R10: `stat_rd` clears `tc_flag` on the next edge. If a terminal transfer happens in the same cycle, the flag is set instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load bases, count and mode; arms the channel |
| cfg_req_base | input | AW | Requester start address |
| cfg_tgt_base | input | AW | Target start address |
| cfg_count | input | CW | Start count (bytes minus one) |
| cfg_tgt_is_dst | input | 1 | 1: target is destination; 0: target is source |
| cfg_req_mod | input | 1 | Requester pointer modify enable |
| cfg_req_down | input | 1 | Requester pointer counts down |
| cfg_req_io | input | 1 | Requester lies in I/O space |
| cfg_req_16 | input | 1 | Requester bus is 16-bit |
| cfg_tgt_mod | input | 1 | Target pointer modify enable |
| cfg_tgt_down | input | 1 | Target pointer counts down |
| cfg_tgt_io | input | 1 | Target lies in I/O space |
| cfg_tgt_16 | input | 1 | Target bus is 16-bit |
| cfg_autoinit | input | 1 | Reload start values on terminal transfer |
| xfer_go | input | 1 | One granted transfer |
| eop | input | 1 | End-of-process, acts with `xfer_go` |
| stat_rd | input | 1 | Status read strobe; clears `tc_flag` |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| src_is_io | output | 1 | Source is in I/O space |
| dst_is_io | output | 1 | Destination is in I/O space |
| xfer_bytes | output | 2 | Bytes moved per transfer |
| cur_count | output | CW | Remaining count |
| chan_active | output | 1 | Channel armed |
| tc_flag | output | 1 | Sticky terminal flag |

## Verification
All state-holding results are registered. After a load, a transfer or a status read applied before a rising edge, the new pointer, count, `chan_active` and `tc_flag` values appear one edge later. The routing of R3 and `xfer_bytes` are combinational from the loaded mode, so they are also valid one edge after the load. The bench drives every stimulus on the falling edge, waits for exactly one rising edge, and compares all outputs at the next falling edge against a model it updates at the same moment. It sweeps all 256 combinations of direction, both modify enables, both count directions, both widths and auto-reload, with 8 transfers each. Directed cases follow for end-of-process, a load that collides with a transfer, and a status read that collides with a terminal transfer.

// File: rtl/dma_seq_pkg.sv
// Package: shared types for the DMA channel sequencer.
// Assumes: widths of a side are either 8 or 16 bits.
package dma_seq_pkg;

    typedef enum logic {
        BUS8  = 1'b0,
        BUS16 = 1'b1
    } bus_width_e;

    typedef struct packed {
        logic       tgt_is_dst;
        logic       req_mod;
        logic       req_down;
        logic       req_io;
        bus_width_e req_w;
        logic       tgt_mod;
        logic       tgt_down;
        logic       tgt_io;
        bus_width_e tgt_w;
        logic       autoinit;
    } chan_mode_t;

    // Pointer step for one side: its bus width in bytes.
    function automatic logic [1:0] side_step(bus_width_e w);
        return (w == BUS16) ? 2'd2 : 2'd1;
    endfunction

    // Bytes moved per transfer: the narrower side limits it.
    function automatic logic [1:0] moved_bytes(bus_width_e a, bus_width_e b);
        return (a == BUS16 && b == BUS16) ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/dma_addr_unit.sv
// Module: one address stream (requester or target).
// Loads a base, steps by its own width in its own direction when modify is
// enabled, and restores the base on reload.
// Assumes: load has priority over reload, and reload over a step.
module dma_addr_unit
    import dma_seq_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] base_i,
    input  logic          mod_en_i,
    input  logic          down_i,
    input  bus_width_e    width_i,
    input  logic          step_i,
    input  logic          reload_i,
    output logic [AW-1:0] addr_o
);

    localparam int PadW = AW - 2;

    logic [AW-1:0] addr_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] delta;
    logic [AW-1:0] addr_next;
    logic          moving;

    // Signed step as a full-width value.
    always_comb begin
        delta  = {{PadW{1'b0}}, side_step(width_i)};
        moving = step_i && mod_en_i;
        if (down_i) begin
            addr_next = addr_q - delta;
        end else begin
            addr_next = addr_q + delta;
        end
    end

    // Base and pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            base_q <= '0;
        end else if (load_i) begin
            addr_q <= base_i;
            base_q <= base_i;
        end else if (reload_i) begin
            addr_q <= base_q;
        end else if (moving) begin
            addr_q <= addr_next;
        end
    end

    assign addr_o = addr_q;

    // R4/R5: with no step enabled the pointer holds.
    a_r4_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !reload_i && !(step_i && mod_en_i)) |=> $stable(addr_q));

    // R4/R5: a step moves the pointer by exactly the side width.
    a_r4_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && mod_en_i && !load_i && !reload_i)
        |=> (($past(down_i) ? ($past(addr_q) - addr_q) : (addr_q - $past(addr_q)))
             == {{PadW{1'b0}}, side_step($past(width_i))}));

    // R8: a reload returns the pointer to the stored base.
    a_r8_addr_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_i && !load_i) |=> (addr_q == base_q));

endmodule

// File: rtl/dma_count_unit.sv
// Module: remaining-count tracker and channel arm state.
// Decides when a transfer is terminal (count below bytes, or end-of-process),
// and either stops the channel or requests a reload.
// Assumes: fire_i is only high while active and not loading.
module dma_count_unit #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] base_i,
    input  logic [1:0]    bytes_i,
    input  logic          fire_i,
    input  logic          eop_i,
    input  logic          autoinit_i,
    output logic          active_o,
    output logic [CW-1:0] count_o,
    output logic          done_o,
    output logic          reload_o
);

    localparam int PadW = CW - 2;

    logic [CW-1:0] count_q;
    logic [CW-1:0] base_q;
    logic          active_q;
    logic [CW-1:0] bytes_w;
    logic          short;

    // Terminal detection for the current transfer.
    always_comb begin
        bytes_w  = {{PadW{1'b0}}, bytes_i};
        short    = (count_q < bytes_w);
        done_o   = fire_i && (short || eop_i);
        reload_o = done_o && autoinit_i;
    end

    // Count, base and arm registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            base_q   <= '0;
            active_q <= 1'b0;
        end else if (load_i) begin
            count_q  <= base_i;
            base_q   <= base_i;
            active_q <= 1'b1;
        end else if (reload_o) begin
            count_q  <= base_q;
        end else if (fire_i) begin
            count_q  <= count_q - bytes_w;
            if (done_o) begin
                active_q <= 1'b0;
            end
        end
    end

    assign active_o = active_q;
    assign count_o  = count_q;

    // R6: a non-terminal transfer lowers the count by the bytes moved.
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && !done_o && !load_i)
        |=> (count_q == $past(count_q) - {{PadW{1'b0}}, $past(bytes_i)}));

    // R7: an idle channel keeps its count.
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !load_i) |=> ($stable(count_q) && !active_q));

    // R8: auto-reload keeps the channel armed and restores the count.
    a_r8_count_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_o && !load_i) |=> (active_q && count_q == base_q));

    // R7: without reload a terminal transfer disarms the channel.
    a_r7_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !autoinit_i && !load_i) |=> !active_q);

endmodule

// File: rtl/dma_route.sv
// Module: maps requester/target streams onto source/destination outputs.
// Assumes: purely combinational; the selection bit is the registered mode.
module dma_route #(
    parameter int AW = 16
) (
    input  logic          tgt_is_dst_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [AW-1:0] tgt_addr_i,
    input  logic          req_io_i,
    input  logic          tgt_io_i,
    output logic [AW-1:0] src_addr_o,
    output logic [AW-1:0] dst_addr_o,
    output logic          src_io_o,
    output logic          dst_io_o
);

    // Side selection by transfer direction.
    always_comb begin
        if (tgt_is_dst_i) begin
            src_addr_o = req_addr_i;
            src_io_o   = req_io_i;
            dst_addr_o = tgt_addr_i;
            dst_io_o   = tgt_io_i;
        end else begin
            src_addr_o = tgt_addr_i;
            src_io_o   = tgt_io_i;
            dst_addr_o = req_addr_i;
            dst_io_o   = req_io_i;
        end
    end

endmodule

// File: rtl/dma_chan_seq.sv
// Module: top of one DMA channel's transfer engine.
// Holds the mode register and the sticky terminal flag, and connects
// two address streams, the count tracker and the side router.
// Assumes: arbitration and the bus cycle itself are handled outside.
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [AW-1:0] cfg_req_base,
    input  logic [AW-1:0] cfg_tgt_base,
    input  logic [CW-1:0] cfg_count,
    input  logic          cfg_tgt_is_dst,
    input  logic          cfg_req_mod,
    input  logic          cfg_req_down,
    input  logic          cfg_req_io,
    input  logic          cfg_req_16,
    input  logic          cfg_tgt_mod,
    input  logic          cfg_tgt_down,
    input  logic          cfg_tgt_io,
    input  logic          cfg_tgt_16,
    input  logic          cfg_autoinit,
    input  logic          xfer_go,
    input  logic          eop,
    input  logic          stat_rd,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic          src_is_io,
    output logic          dst_is_io,
    output logic [1:0]    xfer_bytes,
    output logic [CW-1:0] cur_count,
    output logic          chan_active,
    output logic          tc_flag
);

    chan_mode_t    mode_q;
    chan_mode_t    mode_d;
    logic          tc_q;
    logic          fire;
    logic          done;
    logic          reload;
    logic          active;
    logic [AW-1:0] req_addr;
    logic [AW-1:0] tgt_addr;

    // Assemble the incoming mode word.
    always_comb begin
        mode_d.tgt_is_dst = cfg_tgt_is_dst;
        mode_d.req_mod    = cfg_req_mod;
        mode_d.req_down   = cfg_req_down;
        mode_d.req_io     = cfg_req_io;
        mode_d.req_w      = cfg_req_16 ? BUS16 : BUS8;
        mode_d.tgt_mod    = cfg_tgt_mod;
        mode_d.tgt_down   = cfg_tgt_down;
        mode_d.tgt_io     = cfg_tgt_io;
        mode_d.tgt_w      = cfg_tgt_16 ? BUS16 : BUS8;
        mode_d.autoinit   = cfg_autoinit;
    end

    // Mode register, captured on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (cfg_load) begin
            mode_q <= mode_d;
        end
    end

    // Accepted transfer: armed and not colliding with a load.
    assign fire       = xfer_go && active && !cfg_load;
    assign xfer_bytes = moved_bytes(mode_q.req_w, mode_q.tgt_w);

    // Sticky terminal flag: set wins over a status-read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q <= 1'b0;
        end else if (done) begin
            tc_q <= 1'b1;
        end else if (stat_rd) begin
            tc_q <= 1'b0;
        end
    end

    dma_addr_unit #(.AW(AW)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (cfg_load),
        .base_i   (cfg_req_base),
        .mod_en_i (mode_q.req_mod),
        .down_i   (mode_q.req_down),
        .width_i  (mode_q.req_w),
        .step_i   (fire),
        .reload_i (reload),
        .addr_o   (req_addr)
    );

    dma_addr_unit #(.AW(AW)) u_tgt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (cfg_load),
        .base_i   (cfg_tgt_base),
        .mod_en_i (mode_q.tgt_mod),
        .down_i   (mode_q.tgt_down),
        .width_i  (mode_q.tgt_w),
        .step_i   (fire),
        .reload_i (reload),
        .addr_o   (tgt_addr)
    );

    dma_count_unit #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cfg_load),
        .base_i     (cfg_count),
        .bytes_i    (xfer_bytes),
        .fire_i     (fire),
        .eop_i      (eop),
        .autoinit_i (mode_q.autoinit),
        .active_o   (active),
        .count_o    (cur_count),
        .done_o     (done),
        .reload_o   (reload)
    );

    dma_route #(.AW(AW)) u_route (
        .tgt_is_dst_i (mode_q.tgt_is_dst),
        .req_addr_i   (req_addr),
        .tgt_addr_i   (tgt_addr),
        .req_io_i     (mode_q.req_io),
        .tgt_io_i     (mode_q.tgt_io),
        .src_addr_o   (src_addr),
        .dst_addr_o   (dst_addr),
        .src_io_o     (src_is_io),
        .dst_io_o     (dst_is_io)
    );

    assign chan_active = active;
    assign tc_flag     = tc_q;

    // R10: a status read with no terminal transfer clears the flag.
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !done) |=> !tc_q);

    // R9: end-of-process on an accepted transfer raises the flag.
    a_r9_eop_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_go && eop && active && !cfg_load) |=> tc_q);

    // R2: a load arms the channel.
    a_r2_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> chan_active);

endmodule

// File: tb/dma_chan_seq_tb.sv
`timescale 1ns/1ps
module dma_chan_seq_tb_top;

    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [AW-1:0] cfg_req_base = '0;
    logic [AW-1:0] cfg_tgt_base = '0;
    logic [CW-1:0] cfg_count = '0;
    logic          cfg_tgt_is_dst = 1'b0, cfg_req_mod = 1'b0, cfg_req_down = 1'b0;
    logic          cfg_req_io = 1'b0, cfg_req_16 = 1'b0, cfg_tgt_mod = 1'b0;
    logic          cfg_tgt_down = 1'b0, cfg_tgt_io = 1'b0, cfg_tgt_16 = 1'b0;
    logic          cfg_autoinit = 1'b0;
    logic          xfer_go = 1'b0, eop = 1'b0, stat_rd = 1'b0;
    logic [AW-1:0] src_addr, dst_addr;
    logic          src_is_io, dst_is_io;
    logic [1:0]    xfer_bytes;
    logic [CW-1:0] cur_count;
    logic          chan_active, tc_flag;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Model state
    logic [AW-1:0] m_req, m_tgt, m_rbase, m_tbase;
    logic [CW-1:0] m_cnt, m_cbase;
    logic          m_act, m_tc;

    always #2 clk = ~clk;

    dma_chan_seq #(.AW(AW), .CW(CW)) dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    function automatic logic [1:0] mbytes();
        return (cfg_req_16 && cfg_tgt_16) ? 2'd2 : 2'd1;
    endfunction

    // Compare every output against the model.
    task automatic check_all(input string ctx);
        chk({ctx, " R3 R4 R5 src_addr"}, src_addr, cfg_tgt_is_dst ? m_req : m_tgt);
        chk({ctx, " R3 R4 R5 dst_addr"}, dst_addr, cfg_tgt_is_dst ? m_tgt : m_req);
        chk({ctx, " R3 src_is_io"}, src_is_io, cfg_tgt_is_dst ? cfg_req_io : cfg_tgt_io);
        chk({ctx, " R3 dst_is_io"}, dst_is_io, cfg_tgt_is_dst ? cfg_tgt_io : cfg_req_io);
        chk({ctx, " R6 xfer_bytes"}, xfer_bytes, mbytes());
        chk({ctx, " R6 R7 R8 cur_count"}, cur_count, m_cnt);
        chk({ctx, " R7 R8 chan_active"}, chan_active, m_act);
        chk({ctx, " R7 R9 R10 tc_flag"}, tc_flag, m_tc);
    endtask

    // Load the channel; an optional same-cycle transfer must be ignored (R2).
    task automatic do_load(input logic with_go);
        cfg_load = 1'b1;
        xfer_go  = with_go;
        @(negedge clk);
        cfg_load = 1'b0;
        xfer_go  = 1'b0;
        m_req = cfg_req_base; m_rbase = cfg_req_base;
        m_tgt = cfg_tgt_base; m_tbase = cfg_tgt_base;
        m_cnt = cfg_count;    m_cbase = cfg_count;
        m_act = 1'b1;
    endtask

    // One transfer pulse with optional eop and status read, then model update.
    task automatic do_xfer(input logic e, input logic rd);
        logic [1:0] b;
        logic       term;
        logic [AW-1:0] rs, ts;
        xfer_go = 1'b1; eop = e; stat_rd = rd;
        @(negedge clk);
        xfer_go = 1'b0; eop = 1'b0; stat_rd = 1'b0;
        b    = mbytes();
        term = m_act && ((m_cnt < CW'(b)) || e);
        rs   = cfg_req_16 ? AW'(2) : AW'(1);
        ts   = cfg_tgt_16 ? AW'(2) : AW'(1);
        if (term) m_tc = 1'b1;
        else if (rd) m_tc = 1'b0;
        if (m_act) begin
            if (term && cfg_autoinit) begin
                m_req = m_rbase; m_tgt = m_tbase; m_cnt = m_cbase;
            end else begin
                if (cfg_req_mod) m_req = cfg_req_down ? m_req - rs : m_req + rs;
                if (cfg_tgt_mod) m_tgt = cfg_tgt_down ? m_tgt - ts : m_tgt + ts;
                m_cnt = m_cnt - CW'(b);
                if (term) m_act = 1'b0;
            end
        end
    endtask

    task automatic do_rd();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        m_tc = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        m_req = '0; m_tgt = '0; m_cnt = '0; m_act = 0; m_tc = 0;
        m_rbase = '0; m_tbase = '0; m_cbase = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 chan_active", chan_active, 0);
        chk("R1 tc_flag", tc_flag, 0);
        chk("R1 src_addr", src_addr, 0);
        chk("R1 dst_addr", dst_addr, 0);
        chk("R1 cur_count", cur_count, 0);

        // Sweep every mode combination.
        for (int c = 0; c < 256; c++) begin
            cfg_tgt_is_dst = c[0]; cfg_req_mod = c[1]; cfg_req_down = c[2];
            cfg_tgt_mod = c[3]; cfg_tgt_down = c[4]; cfg_req_16 = c[5];
            cfg_tgt_16 = c[6]; cfg_autoinit = c[7];
            cfg_req_io = c[1] ^ c[4]; cfg_tgt_io = c[2] ^ c[5];
            cfg_req_base = 16'h0100 + AW'(c);
            cfg_tgt_base = 16'h8000 - AW'(c);
            cfg_count = 16'd5;
            do_load(c[0] & c[3]);
            check_all("R2 load");
            for (int k = 0; k < 8; k++) begin
                do_xfer(1'b0, 1'b0);
                check_all("sweep");
            end
            do_rd();
            check_all("R10 read");
        end

        // R9: end-of-process stops a non-reload channel early.
        cfg_autoinit = 1'b0; cfg_req_16 = 1'b0; cfg_tgt_16 = 1'b0;
        cfg_req_mod = 1'b1; cfg_tgt_mod = 1'b1; cfg_req_down = 1'b0; cfg_tgt_down = 1'b1;
        cfg_count = 16'd20;
        do_load(1'b0);
        do_xfer(1'b0, 1'b0);
        do_xfer(1'b1, 1'b0);
        check_all("R9 eop stop");
        chk("R9 inactive after eop", chan_active, 0);
        do_xfer(1'b0, 1'b0);
        check_all("R7 ignored while idle");

        // R9 + R8: end-of-process with auto-reload returns to start.
        cfg_autoinit = 1'b1;
        do_load(1'b0);
        do_rd();
        do_xfer(1'b0, 1'b0);
        do_xfer(1'b0, 1'b0);
        do_xfer(1'b1, 1'b0);
        check_all("R9 R8 eop reload");
        chk("R8 count restored", cur_count, 16'd20);

        // R10: a terminal transfer beats a same-cycle status read.
        cfg_count = 16'd0;
        do_load(1'b0);
        do_rd();
        chk("R10 cleared", tc_flag, 0);
        do_xfer(1'b0, 1'b1);
        chk("R10 set wins", tc_flag, 1);
        check_all("R10 collide");

        // R7: 16-bit wrap of the count on a non-reload terminal transfer.
        cfg_autoinit = 1'b0; cfg_req_16 = 1'b1; cfg_tgt_16 = 1'b1;
        cfg_count = 16'd1;
        do_load(1'b0);
        do_xfer(1'b0, 1'b0);
        chk("R7 count wrap", cur_count, 16'hFFFF);
        check_all("R7 wrap");

        finish_run();
    end

endmodule